// File: doc/BRIEF.md
# Parallel-Port Nibble Register Sequencer

This block sits on the host side of a PC-style parallel port and reaches the registers of a parallel-to-IDE bridge. It drives the 8-bit data port and the 4-bit control port, and reads the 8-bit status port. It offers four operations: register read, register write, connect and disconnect. A read or write names one of two register banks (the register file or the command set) and a 3-bit register index. The sequencer turns that into a fixed series of port writes. A read rebuilds its byte from the upper nibbles of two status samples, since only four status lines are useful per phase.

Each port step is held for `HOLD` clock cycles, and the status port is sampled on the last cycle of a step. Connect remembers the port values the sequencer found. Disconnect sends a release address and then puts those values back. Requests use a valid/ready handshake. While an operation is in flight, new requests are refused and dropped.

Top module: `ppnib_seq`

## Requirements
- R1: The address byte sent on the data port is the register index plus 0x08 when `req_cmdset` is 0 (register file), or plus 0x10 when `req_cmdset` is 1 (command set).
- R2: Reads, writes and disconnects begin with the same nine steps, in this order: control 4, data = address byte, then control 0xC, 0xE, 0xE, 0xC, 4, 4, 4.
- R3: A read (`req_op` = 0) follows the shared steps with control 6 (status sampled as the low sample), then control 4 (status sampled as the high sample), then a final control 4. That is 12 steps in all.
- R4: The read result on `rd_data` has bits 7:4 of the high sample in bits 7:4 and bits 7:4 of the low sample in bits 3:0. Each sample is taken on the last cycle of its step.
- R5: A write (`req_op` = 1) follows the shared steps with data = `req_wdata`, then control 5, 7, 5, 4. That is 14 steps in all.
- R6: A connect (`req_op` = 2) captures `pp_data_in` and `pp_ctrl_in` at acceptance. It then drives control 4 for one step and leaves the data port unchanged.
- R7: A disconnect (`req_op` = 3) runs the shared steps with address byte 0x20, then drives the saved data value, then the saved control value. That is 11 steps in all.
- R8: Each step's port value appears in the cycle after the previous step ends and is held for exactly `HOLD` cycles. When idle, the port outputs do not change.
- R9: `busy` is high from the cycle after acceptance for steps×`HOLD` cycles. `done` is then high for exactly one cycle, with `busy` low. `rd_data` is updated only by reads.
- R10: `req_ready` equals the inverse of `busy`. A request presented while busy is neither accepted nor queued, and it does not disturb the running sequence.
- R11: After reset, control output is 4, data output is 0, `busy` and `done` are 0, `rd_data` is 0, `req_ready` is 1, the saved control value is 4 and the saved data value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_op | input | 2 | 0 read, 1 write, 2 connect, 3 disconnect |
| req_cmdset | input | 1 | Bank select: 0 register file, 1 command set |
| req_idx | input | 3 | Register index within the bank |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle end-of-operation pulse |
| rd_data | output | 8 | Rebuilt read byte |
| pp_data_out | output | 8 | Parallel data port drive |
| pp_ctrl_out | output | 4 | Parallel control port drive |
| pp_data_in | input | 8 | Current data port value, captured on connect |
| pp_ctrl_in | input | 4 | Current control port value, captured on connect |
| pp_status_in | input | 8 | Parallel status port |

## Verification
The hardest case to reach is a request that arrives in the middle of a running sequence. The sequencer must refuse it without any visible effect. To create it, the stimulus raises `req_valid` with a different operation for several cycles during the latch steps of reads, writes and disconnects. It then checks on every cycle that the port sequence still matches the expected one and that no second operation starts after `done`. The nibble rebuild is exercised by a status model keyed on the control value, which places different upper and lower nibbles in the two phases. This way a swapped or misaligned sample shows up in `rd_data`.

// File: rtl/ppnib_pkg.sv
package ppnib_pkg;
  localparam int PP_DATA_W = 8;
  localparam int PP_CTRL_W = 4;
  localparam int IDX_W     = 3;
  localparam int NIB_W     = PP_DATA_W / 2;
  localparam int STEP_W    = 4;

  localparam logic [PP_DATA_W-1:0] BASE_REGFILE = 8'h08;
  localparam logic [PP_DATA_W-1:0] BASE_CMDSET  = 8'h10;
  localparam logic [PP_DATA_W-1:0] ADDR_RELEASE = 8'h20;
  localparam logic [PP_CTRL_W-1:0] CTRL_REST    = 4'h4;

  typedef enum logic [1:0] {
    OP_READ       = 2'd0,
    OP_WRITE      = 2'd1,
    OP_CONNECT    = 2'd2,
    OP_DISCONNECT = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SRC_ADDR  = 2'd0,
    SRC_WDATA = 2'd1,
    SRC_SAVED = 2'd2
  } dsrc_e;

  typedef struct packed {
    logic                 wr_ctrl;
    logic                 ctrl_saved;
    logic [PP_CTRL_W-1:0] ctrl;
    logic                 wr_data;
    dsrc_e                dsrc;
    logic                 samp_lo;
    logic                 samp_hi;
    logic                 last;
  } step_t;

  function automatic step_t mk_ctrl(logic [PP_CTRL_W-1:0] v, logic lo, logic hi, logic fin);
    step_t s;
    s = '0;
    s.wr_ctrl = 1'b1;
    s.ctrl    = v;
    s.samp_lo = lo;
    s.samp_hi = hi;
    s.last    = fin;
    return s;
  endfunction

  function automatic step_t mk_data(dsrc_e src);
    step_t s;
    s = '0;
    s.wr_data = 1'b1;
    s.dsrc    = src;
    return s;
  endfunction

  // Address latch strobe: seven control values applied after the address byte
  function automatic logic [PP_CTRL_W-1:0] latch_ctrl(logic [STEP_W-1:0] k);
    case (k)
      4'd0, 4'd3: return 4'hC;
      4'd1, 4'd2: return 4'hE;
      default:    return 4'h4;
    endcase
  endfunction
endpackage

// File: rtl/ppnib_hold_timer.sv
module ppnib_hold_timer #(
  parameter int HOLD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic expire
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;

  logic [CW-1:0] cnt;

  assign expire = run && (cnt == CW'(HOLD - 1));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= expire ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ppnib_prog.sv
module ppnib_prog
  import ppnib_pkg::*;
(
  input  op_e               op,
  input  logic [STEP_W-1:0] idx,
  output step_t             st
);
  always_comb begin
    st = '0;
    if (op == OP_CONNECT) begin
      st = mk_ctrl(CTRL_REST, 1'b0, 1'b0, 1'b1);
    end else if (idx == 4'd0) begin
      st = mk_ctrl(CTRL_REST, 1'b0, 1'b0, 1'b0);
    end else if (idx == 4'd1) begin
      st = mk_data(SRC_ADDR);
    end else if (idx <= 4'd8) begin
      st = mk_ctrl(latch_ctrl(idx - 4'd2), 1'b0, 1'b0, 1'b0);
    end else begin
      case (op)
        OP_READ: begin
          case (idx)
            4'd9:    st = mk_ctrl(4'h6, 1'b1, 1'b0, 1'b0);
            4'd10:   st = mk_ctrl(4'h4, 1'b0, 1'b1, 1'b0);
            default: st = mk_ctrl(4'h4, 1'b0, 1'b0, 1'b1);
          endcase
        end
        OP_WRITE: begin
          case (idx)
            4'd9:    st = mk_data(SRC_WDATA);
            4'd10:   st = mk_ctrl(4'h5, 1'b0, 1'b0, 1'b0);
            4'd11:   st = mk_ctrl(4'h7, 1'b0, 1'b0, 1'b0);
            4'd12:   st = mk_ctrl(4'h5, 1'b0, 1'b0, 1'b0);
            default: st = mk_ctrl(4'h4, 1'b0, 1'b0, 1'b1);
          endcase
        end
        default: begin
          if (idx == 4'd9) begin
            st = mk_data(SRC_SAVED);
          end else begin
            st = mk_ctrl(4'h0, 1'b0, 1'b0, 1'b1);
            st.ctrl_saved = 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ppnib_seq.sv
module ppnib_seq
  import ppnib_pkg::*;
#(
  parameter int HOLD = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [1:0]           req_op,
  input  logic                 req_cmdset,
  input  logic [IDX_W-1:0]     req_idx,
  input  logic [PP_DATA_W-1:0] req_wdata,
  output logic                 busy,
  output logic                 done,
  output logic [PP_DATA_W-1:0] rd_data,
  output logic [PP_DATA_W-1:0] pp_data_out,
  output logic [PP_CTRL_W-1:0] pp_ctrl_out,
  input  logic [PP_DATA_W-1:0] pp_data_in,
  input  logic [PP_CTRL_W-1:0] pp_ctrl_in,
  input  logic [PP_DATA_W-1:0] pp_status_in
);
  logic                 busy_q;
  op_e                  op_q;
  logic [STEP_W-1:0]    step_q;
  step_t                cur_q;
  step_t                nxt_st;
  op_e                  prog_op;
  logic [STEP_W-1:0]    prog_idx;
  logic [PP_DATA_W-1:0] addr_q;
  logic [PP_DATA_W-1:0] wd_q;
  logic [PP_DATA_W-1:0] saved_d;
  logic [PP_CTRL_W-1:0] saved_c;
  logic [NIB_W-1:0]     lo_nib;
  logic [NIB_W-1:0]     hi_nib;
  logic                 accept;
  logic                 step_end;

  assign accept    = req_valid && !busy_q;
  assign req_ready = !busy_q;
  assign busy      = busy_q;

  // The program is always asked for the step that is applied next
  assign prog_op  = busy_q ? op_q : op_e'(req_op);
  assign prog_idx = busy_q ? step_q + 1'b1 : '0;

  ppnib_prog u_prog (
    .op  (prog_op),
    .idx (prog_idx),
    .st  (nxt_st)
  );

  ppnib_hold_timer #(.HOLD(HOLD)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (accept),
    .run     (busy_q),
    .expire  (step_end)
  );

  function automatic logic [PP_DATA_W-1:0] pick_data(dsrc_e s);
    case (s)
      SRC_ADDR:  return addr_q;
      SRC_WDATA: return wd_q;
      default:   return saved_d;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      done        <= 1'b0;
      rd_data     <= '0;
      pp_ctrl_out <= CTRL_REST;
      pp_data_out <= '0;
      saved_c     <= CTRL_REST;
      saved_d     <= '0;
      op_q        <= OP_READ;
      step_q      <= '0;
      cur_q       <= '0;
      addr_q      <= '0;
      wd_q        <= '0;
      lo_nib      <= '0;
      hi_nib      <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        op_q   <= op_e'(req_op);
        wd_q   <= req_wdata;
        step_q <= '0;
        cur_q  <= nxt_st;
        if (op_e'(req_op) == OP_DISCONNECT)
          addr_q <= ADDR_RELEASE;
        else
          addr_q <= (req_cmdset ? BASE_CMDSET : BASE_REGFILE)
                    + {{(PP_DATA_W-IDX_W){1'b0}}, req_idx};
        if (op_e'(req_op) == OP_CONNECT) begin
          saved_d <= pp_data_in;
          saved_c <= pp_ctrl_in;
        end
        if (nxt_st.wr_ctrl) pp_ctrl_out <= nxt_st.ctrl;
      end else if (step_end) begin
        if (cur_q.samp_lo) lo_nib <= pp_status_in[PP_DATA_W-1 -: NIB_W];
        if (cur_q.samp_hi) hi_nib <= pp_status_in[PP_DATA_W-1 -: NIB_W];
        if (cur_q.last) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
          if (op_q == OP_READ) rd_data <= {hi_nib, lo_nib};
        end else begin
          step_q <= prog_idx;
          cur_q  <= nxt_st;
          if (nxt_st.wr_ctrl)
            pp_ctrl_out <= nxt_st.ctrl_saved ? saved_c : nxt_st.ctrl;
          if (nxt_st.wr_data)
            pp_data_out <= pick_data(nxt_st.dsrc);
        end
      end
    end
  end
endmodule

// File: rtl/ppnib_seq_chk.sv
module ppnib_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic       busy,
  input logic       done,
  input logic [7:0] pp_data_out,
  input logic [3:0] pp_ctrl_out
);
  a_r10_ready_vs_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !req_ready);

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  a_r2_accept_rest_ctrl: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (busy && pp_ctrl_out == 4'h4));

  a_r8_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(req_valid && req_ready)) |=> ($stable(pp_ctrl_out) && $stable(pp_data_out)));
endmodule

bind ppnib_seq ppnib_seq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .busy        (busy),
  .done        (done),
  .pp_data_out (pp_data_out),
  .pp_ctrl_out (pp_ctrl_out)
);

// File: tb/sim_ppnib_seq.sv
`timescale 1ns/1ps
module sim_ppnib_seq;
  localparam int HOLD = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_op = 2'd0;
  logic       req_cmdset = 1'b0;
  logic [2:0] req_idx = 3'd0;
  logic [7:0] req_wdata = 8'h00;
  logic       busy, done;
  logic [7:0] rd_data, pp_data_out;
  logic [3:0] pp_ctrl_out;
  logic [7:0] pp_data_in = 8'h5A;
  logic [3:0] pp_ctrl_in = 4'hB;
  logic [7:0] stat_lo = 8'h00, stat_hi = 8'h00;
  logic [7:0] pp_status_in;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // External device model: status depends on the control lines
  assign pp_status_in = (pp_ctrl_out == 4'h6) ? stat_lo :
                        (pp_ctrl_out == 4'h4) ? stat_hi : 8'hFF;

  always #2 clk = ~clk;

  ppnib_seq #(.HOLD(HOLD)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_cmdset(req_cmdset), .req_idx(req_idx),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
    .pp_data_out(pp_data_out), .pp_ctrl_out(pp_ctrl_out),
    .pp_data_in(pp_data_in), .pp_ctrl_in(pp_ctrl_in),
    .pp_status_in(pp_status_in)
  );

  // Reference model state
  logic [3:0] m_c = 4'h4;
  logic [7:0] m_d = 8'h00;
  logic [3:0] m_sc = 4'h4;
  logic [7:0] m_sd = 8'h00;
  logic [7:0] m_rd = 8'h00;
  logic [3:0] q_c[$];
  logic [7:0] q_d[$];
  string      q_t[$];

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic add_c(logic [3:0] v, string tag);
    m_c = v; q_c.push_back(m_c); q_d.push_back(m_d); q_t.push_back(tag);
  endtask

  task automatic add_d(logic [7:0] v, string tag);
    m_d = v; q_c.push_back(m_c); q_d.push_back(m_d); q_t.push_back(tag);
  endtask

  task automatic add_prefix(logic [7:0] addr);
    add_c(4'h4, "R2");
    add_d(addr, "R1");
    add_c(4'hC, "R2"); add_c(4'hE, "R2"); add_c(4'hE, "R2"); add_c(4'hC, "R2");
    add_c(4'h4, "R2"); add_c(4'h4, "R2"); add_c(4'h4, "R2");
  endtask

  task automatic run_op(int op, bit cs, int idx, logic [7:0] wd, bit poke);
    int n;
    q_c.delete(); q_d.delete(); q_t.delete();
    case (op)
      0: begin
        add_prefix(8'((cs ? 8'h10 : 8'h08) + idx));
        add_c(4'h6, "R3"); add_c(4'h4, "R3"); add_c(4'h4, "R3");
        m_rd = {stat_hi[7:4], stat_lo[7:4]};
      end
      1: begin
        add_prefix(8'((cs ? 8'h10 : 8'h08) + idx));
        add_d(wd, "R5");
        add_c(4'h5, "R5"); add_c(4'h7, "R5"); add_c(4'h5, "R5"); add_c(4'h4, "R5");
      end
      2: begin
        m_sd = pp_data_in; m_sc = pp_ctrl_in;
        add_c(4'h4, "R6");
      end
      default: begin
        add_prefix(8'h20);
        add_d(m_sd, "R7");
        add_c(m_sc, "R7");
      end
    endcase
    n = q_c.size();
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "ready before request", req_ready, 1);
    req_op = 2'(op); req_cmdset = cs; req_idx = 3'(idx); req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int s = 0; s < n; s++) begin
      for (int h = 0; h < HOLD; h++) begin
        chk(pp_ctrl_out == q_c[s], q_t[s], $sformatf("ctrl step %0d", s), pp_ctrl_out, q_c[s]);
        chk(pp_data_out == q_d[s], q_t[s], $sformatf("data step %0d", s), pp_data_out, q_d[s]);
        chk(busy == 1'b1 && done == 1'b0, "R9", "busy/done in flight", {busy, done}, 2);
        chk(req_ready == 1'b0, "R10", "ready while busy", req_ready, 0);
        if (poke && s == 2 && h == 0) begin
          req_op = 2'd2; req_valid = 1'b1;
        end
        if (poke && s == 4 && h == 0) req_valid = 1'b0;
        @(negedge clk);
      end
    end
    chk(done == 1'b1 && busy == 1'b0, "R9", "end pulse", {busy, done}, 1);
    chk(rd_data == m_rd, op == 0 ? "R4" : "R9", "rd_data", rd_data, m_rd);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R10", "no queued request", {busy, done}, 0);
    chk(pp_ctrl_out == m_c && pp_data_out == m_d, "R8", "idle ports",
        {pp_ctrl_out, pp_data_out}, {m_c, m_d});
    repeat (2) @(negedge clk);
    chk(pp_ctrl_out == m_c && pp_data_out == m_d, "R8", "idle ports hold",
        {pp_ctrl_out, pp_data_out}, {m_c, m_d});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(pp_ctrl_out == 4'h4 && pp_data_out == 8'h00, "R11", "reset ports",
        {pp_ctrl_out, pp_data_out}, 12'h400);
    chk(busy == 0 && done == 0 && rd_data == 0 && req_ready == 1, "R11", "reset flags",
        {busy, done, req_ready}, 1);

    // R11: disconnect before any connect restores reset-saved values
    run_op(3, 0, 0, 8'h00, 0);

    stat_lo = 8'hA7; stat_hi = 8'h3C;
    run_op(0, 0, 2, 8'h00, 0);              // R1 register file, R3, R4
    stat_lo = 8'h5F; stat_hi = 8'hC0;
    run_op(0, 1, 7, 8'h00, 1);              // R1 command set, R10 poke
    run_op(1, 0, 6, 8'hA0, 1);              // R5 with poke
    run_op(1, 1, 0, 8'hFF, 0);              // R5 command set
    pp_data_in = 8'h96; pp_ctrl_in = 4'hB;
    run_op(2, 0, 0, 8'h00, 0);              // R6
    pp_data_in = 8'h11; pp_ctrl_in = 4'h0;  // must not affect saved values
    run_op(3, 0, 0, 8'h00, 1);              // R7 restores 0x96 / 0xB
    stat_lo = 8'h0E; stat_hi = 8'hF1;
    run_op(0, 1, 3, 8'h00, 0);              // R4 after disconnect

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule